// File: doc/BRIEF.md
# Neural Array Cycle Sequencer

This block sequences one chip of six neuron cells through their processing rounds and owns the chip's only path to a shared 2K x 8 RAM. The RAM holds a 256-byte activation-function table for each neuron and a mailbox page for the host. At the start of each round the sequencer reads a per-neuron source-select byte. It then services the neurons one at a time over the shared internal byte bus, from neuron 5 down to neuron 0. Each neuron receives either a table entry, indexed by the high byte of its own accumulator, or a value that the host has placed in that neuron's input slot.

After this burst the sequencer drives the cell strobes that clear the accumulators, preload the activations, and then step through each router level. A level consists of token advance, activation shift, weight shift, two 8-step multiply passes and one carry cycle. The number of levels is a parameter. When the last level has finished, the accumulator high bytes are written to the host output slots and a done pulse is raised. In debug mode the output slots are written after every level, the block pauses between levels while the host holds its wait line, and no done pulse is raised.

The host wait line is looked at only at the fixed stopping points. The neuron arithmetic itself sits outside this block.

Top module: `neuro_seq`

## Requirements
- R1: While reset is asserted and after its release, ramRd, ramWr, cellCtl, endSmall and doneBig are all 0 until the host releases waitReq.
- R2: While waitReq is high at the start-of-round stopping point there is no RAM access and no cell strobe. After the clock edge that samples waitReq low there, the next cycle reads address 0x7FF, which is the source-select byte.
- R3: The service burst is the source-select read followed by six lookup reads for neurons 5, 4, 3, 2, 1, 0 in that order, one read every 2 clocks. The last lookup read comes 12 clocks after the source-select read.
- R4: The lookup address for neuron n is {n[2:0], accHigh} when bit n of the source-select byte is 0, and 0x700+n when it is 1. Bits 6 and 7 of that byte have no effect.
- R5: In the clock after each lookup read, cellCtl bit 0 (load) is high, neuronSel equals n, and actData carries the RAM read data.
- R6: Cell strobe encoding: bit 1 clear is high for 1 clock, then bit 2 preload for 8 clocks, once per round. Each level then runs bit 3 token for 2 clocks, bit 4 activation shift for 8, bit 5 weight shift for 8, bit 6 forward multiply for 8, bit 7 backward multiply for 8 and bit 8 carry for 1. At most one cellCtl bit is high in any cycle.
- R7: endSmall is a one-clock pulse, once per pass over all BW levels, in the clock after the carry cycle of the last level.
- R8: In normal mode the last level is followed directly (the clock after endSmall) by six writes to 0x708+n for n = 5 down to 0. Each write carries accHigh of the selected neuron, with cellCtl bit 9 (read accumulator) high.
- R9: In normal mode doneBig is a one-clock pulse in the clock after the last output write. The source-select read and doneBig are 29+36*BW clocks apart.
- R10: In debug mode the six output writes follow every level, for 6*BW writes per round, and doneBig never rises.
- R11: In debug mode, after each level's writes the block stays idle, with no RAM access and no cell strobe, for as long as waitReq is high.
- R12: Changes of waitReq between stopping points have no effect on the addresses, data or timing of a round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| waitReq | input | 1 | Host hold request, sampled at stopping points |
| debugMode | input | 1 | 1 = write outputs and pause after every level |
| ramAddr | output | 11 | RAM address {page, argument} |
| ramRd | output | 1 | RAM read strobe; data is returned the next clock |
| ramWr | output | 1 | RAM write strobe |
| ramRdData | input | 8 | RAM read data |
| ramWrData | output | 8 | RAM write data |
| neuronSel | output | 3 | Neuron selected on the internal bus |
| accHigh | input | 8 | Accumulator high byte of the selected neuron |
| actData | output | 8 | New activation byte driven to the selected neuron |
| cellCtl | output | 10 | One-hot cell strobes, bit map in R5, R6 and R8 |
| endSmall | output | 1 | Pulse when the level counter wraps to zero |
| doneBig | output | 1 | Round complete pulse (normal mode) |

## Verification
The hardest case to reach from the ports is the pause inside a debug round. The host has to raise waitReq in the narrow window between the sixth output write of a level and the next edge, so that the block is caught at its between-levels stopping point instead of going on to the next level. The bench watches the write strobe at each falling edge and raises waitReq right after the sixth write. It holds waitReq for twenty clocks and checks that no strobe moves, then releases it and checks that the rest of the round keeps its full write pattern. A second hard case is a waitReq pulse in the middle of a normal round, which must leave the round length exactly at its formula value.

// File: rtl/neuro_seq_pkg.sv
package neuro_seq_pkg;

  localparam int ARG_W  = 8;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = SEL_W + ARG_W;
  localparam int CC_W   = 10;

  localparam int CC_LOAD  = 0;
  localparam int CC_CLR   = 1;
  localparam int CC_PRE   = 2;
  localparam int CC_TOKEN = 3;
  localparam int CC_ACT   = 4;
  localparam int CC_WGT   = 5;
  localparam int CC_MULF  = 6;
  localparam int CC_MULB  = 7;
  localparam int CC_CARRY = 8;
  localparam int CC_RDACC = 9;

  localparam logic [SEL_W-1:0] MBOX_PAGE = '1;

  typedef enum logic [1:0] {
    ADDR_NONE,
    ADDR_DIR,
    ADDR_LOOK,
    ADDR_OUT
  } addrSel_e;

  typedef struct packed {
    logic     dirLoad;
    logic     iocLoad;
    logic     iocDec;
    addrSel_e addrSel;
  } dpStrobe_t;

  typedef enum logic [4:0] {
    S_IDLE,
    S_DIR_ADDR,
    S_DIR_CAP,
    S_LOOK_ADDR,
    S_LOOK_CAP,
    S_INIT,
    S_PRE,
    S_TOKEN,
    S_ACT,
    S_WGT,
    S_MULF,
    S_MULB,
    S_CARRY,
    S_LVL_END,
    S_OUT,
    S_DBG_HOLD,
    S_DONE
  } seqState_e;

endpackage

// File: rtl/neuro_seq_dpath.sv
module neuro_seq_dpath
  import neuro_seq_pkg::*;
#(
  parameter int NEURONS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [ARG_W-1:0]    ramRdData,
  input  logic [ARG_W-1:0]    accHigh,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [ARG_W-1:0]    ramWrData,
  output logic [ARG_W-1:0]    actData,
  output logic [SEL_W-1:0]    neuronSel,
  output logic                iocZero
);

  localparam logic [SEL_W-1:0] IOC_TOP = SEL_W'(NEURONS - 1);
  localparam int PAD_W = ARG_W - SEL_W;

  logic [ARG_W-1:0] dirReg;
  logic [SEL_W-1:0] ioCnt;
  logic             useInput;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '0;
      ioCnt  <= '0;
    end else begin
      if (strb.dirLoad) dirReg <= ramRdData;
      if (strb.iocLoad)     ioCnt <= IOC_TOP;
      else if (strb.iocDec) ioCnt <= ioCnt - 1'b1;
    end
  end

  assign useInput = dirReg[ioCnt];

  always_comb begin
    unique case (strb.addrSel)
      ADDR_DIR:  ramAddr = {MBOX_PAGE, {ARG_W{1'b1}}};
      ADDR_LOOK: ramAddr = useInput ? {MBOX_PAGE, {PAD_W{1'b0}}, ioCnt}
                                    : {ioCnt, accHigh};
      ADDR_OUT:  ramAddr = {MBOX_PAGE, {(PAD_W-1){1'b0}}, 1'b1, ioCnt};
      default:   ramAddr = '0;
    endcase
  end

  assign ramWrData = accHigh;
  assign actData   = ramRdData;
  assign neuronSel = ioCnt;
  assign iocZero   = (ioCnt == '0);

endmodule

// File: rtl/neuro_seq_ctrl.sv
module neuro_seq_ctrl
  import neuro_seq_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            waitReq,
  input  logic            debugMode,
  input  logic            iocZero,
  output dpStrobe_t       strb,
  output logic            ramRd,
  output logic            ramWr,
  output logic [CC_W-1:0] cellCtl,
  output logic            endSmall,
  output logic            doneBig
);

  localparam int BW_W = (BW > 1) ? $clog2(BW) : 1;
  localparam logic [BW_W-1:0] BW_LAST = BW_W'(BW - 1);

  seqState_e       state, stateNext;
  logic [2:0]      stepCnt;
  logic            stepLast;
  logic [BW_W-1:0] bwCnt;
  logic            lastLvl;
  logic            dbgPass;

  assign lastLvl = (bwCnt == BW_LAST);

  // Length of the multi-cycle phases: 8 bit steps, 2 for the token move.
  always_comb begin
    unique case (state)
      S_PRE, S_ACT, S_WGT, S_MULF, S_MULB: stepLast = (stepCnt == 3'd7);
      S_TOKEN:                             stepLast = (stepCnt == 3'd1);
      default:                             stepLast = 1'b1;
    endcase
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:      if (!waitReq) stateNext = S_DIR_ADDR;
      S_DIR_ADDR:  stateNext = S_DIR_CAP;
      S_DIR_CAP:   stateNext = S_LOOK_ADDR;
      S_LOOK_ADDR: stateNext = S_LOOK_CAP;
      S_LOOK_CAP:  stateNext = iocZero ? S_INIT : S_LOOK_ADDR;
      S_INIT:      stateNext = S_PRE;
      S_PRE:       if (stepLast) stateNext = S_TOKEN;
      S_TOKEN:     if (stepLast) stateNext = S_ACT;
      S_ACT:       if (stepLast) stateNext = S_WGT;
      S_WGT:       if (stepLast) stateNext = S_MULF;
      S_MULF:      if (stepLast) stateNext = S_MULB;
      S_MULB:      if (stepLast) stateNext = S_CARRY;
      S_CARRY:     stateNext = S_LVL_END;
      S_LVL_END: begin
        if (debugMode || lastLvl) stateNext = S_OUT;
        else                      stateNext = S_TOKEN;
      end
      S_OUT: begin
        if (iocZero) stateNext = dbgPass ? S_DBG_HOLD : S_DONE;
      end
      S_DBG_HOLD: begin
        if (!waitReq) stateNext = (bwCnt == '0) ? S_IDLE : S_TOKEN;
      end
      S_DONE:      stateNext = S_IDLE;
      default:     stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      bwCnt   <= '0;
      dbgPass <= 1'b0;
    end else begin
      state   <= stateNext;
      stepCnt <= (stateNext != state) ? 3'd0 : stepCnt + 3'd1;
      if (state == S_INIT) bwCnt <= '0;
      if (state == S_LVL_END) begin
        bwCnt   <= lastLvl ? '0 : bwCnt + 1'b1;
        dbgPass <= debugMode;
      end
    end
  end

  always_comb begin
    cellCtl = '0;
    unique case (state)
      S_LOOK_CAP: cellCtl[CC_LOAD]  = 1'b1;
      S_INIT:     cellCtl[CC_CLR]   = 1'b1;
      S_PRE:      cellCtl[CC_PRE]   = 1'b1;
      S_TOKEN:    cellCtl[CC_TOKEN] = 1'b1;
      S_ACT:      cellCtl[CC_ACT]   = 1'b1;
      S_WGT:      cellCtl[CC_WGT]   = 1'b1;
      S_MULF:     cellCtl[CC_MULF]  = 1'b1;
      S_MULB:     cellCtl[CC_MULB]  = 1'b1;
      S_CARRY:    cellCtl[CC_CARRY] = 1'b1;
      S_OUT:      cellCtl[CC_RDACC] = 1'b1;
      default:    cellCtl = '0;
    endcase
  end

  always_comb begin
    strb.dirLoad = (state == S_DIR_CAP);
    strb.iocLoad = (state == S_DIR_CAP) ||
                   ((state == S_LVL_END) && (debugMode || lastLvl));
    strb.iocDec  = ((state == S_LOOK_CAP) || (state == S_OUT)) && !iocZero;
    unique case (state)
      S_DIR_ADDR:  strb.addrSel = ADDR_DIR;
      S_LOOK_ADDR: strb.addrSel = ADDR_LOOK;
      S_OUT:       strb.addrSel = ADDR_OUT;
      default:     strb.addrSel = ADDR_NONE;
    endcase
  end

  assign ramRd    = (state == S_DIR_ADDR) || (state == S_LOOK_ADDR);
  assign ramWr    = (state == S_OUT);
  assign endSmall = (state == S_LVL_END) && lastLvl;
  assign doneBig  = (state == S_DONE);

endmodule

// File: rtl/neuro_seq.sv
module neuro_seq
  import neuro_seq_pkg::*;
#(
  parameter int NEURONS = 6,
  parameter int BW      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        waitReq,
  input  logic        debugMode,
  output logic [10:0] ramAddr,
  output logic        ramRd,
  output logic        ramWr,
  input  logic [7:0]  ramRdData,
  output logic [7:0]  ramWrData,
  output logic [2:0]  neuronSel,
  input  logic [7:0]  accHigh,
  output logic [7:0]  actData,
  output logic [9:0]  cellCtl,
  output logic        endSmall,
  output logic        doneBig
);

  dpStrobe_t strb;
  logic      iocZero;

  neuro_seq_ctrl #(.BW(BW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .waitReq   (waitReq),
    .debugMode (debugMode),
    .iocZero   (iocZero),
    .strb      (strb),
    .ramRd     (ramRd),
    .ramWr     (ramWr),
    .cellCtl   (cellCtl),
    .endSmall  (endSmall),
    .doneBig   (doneBig)
  );

  neuro_seq_dpath #(.NEURONS(NEURONS)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .ramRdData (ramRdData),
    .accHigh   (accHigh),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .actData   (actData),
    .neuronSel (neuronSel),
    .iocZero   (iocZero)
  );

endmodule

// File: rtl/neuro_seq_checks.sv
module neuro_seq_checks (
  input logic        clk,
  input logic        rstN,
  input logic [10:0] ramAddr,
  input logic        ramRd,
  input logic        ramWr,
  input logic [2:0]  neuronSel,
  input logic [9:0]  cellCtl,
  input logic        endSmall,
  input logic        doneBig
);

  a_r1_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRd && ramWr));

  a_r3_dir_gap: assert property (@(posedge clk) disable iff (!rstN)
    (ramRd && ramAddr == 11'h7FF) |=> !ramRd && !ramWr);

  a_r4_lookup_addr: assert property (@(posedge clk) disable iff (!rstN)
    (ramRd && ramAddr != 11'h7FF) |->
      (ramAddr[10:8] == neuronSel) || (ramAddr == {8'hE0, neuronSel}));

  a_r5_load_after_read: assert property (@(posedge clk) disable iff (!rstN)
    cellCtl[0] |-> $past(ramRd));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cellCtl));

  a_r7_end_pulse: assert property (@(posedge clk) disable iff (!rstN)
    endSmall |=> !endSmall);

  a_r8_out_slot: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> (ramAddr == {8'hE1, neuronSel}) && cellCtl[9]);

  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    doneBig |-> $past(ramWr) && !ramWr);

endmodule

bind neuro_seq neuro_seq_checks chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .ramAddr   (ramAddr),
  .ramRd     (ramRd),
  .ramWr     (ramWr),
  .neuronSel (neuronSel),
  .cellCtl   (cellCtl),
  .endSmall  (endSmall),
  .doneBig   (doneBig)
);

// File: tb/neuro_seq_tb_top.sv
module neuro_seq_tb_top;

  localparam int BW   = 4;
  localparam int NEUR = 6;

  logic        clk = 1'b0;
  logic        rstN, waitReq, debugMode;
  logic [10:0] ramAddr;
  logic        ramRd, ramWr;
  logic [7:0]  ramRdData, ramWrData, accHigh, actData;
  logic [2:0]  neuronSel;
  logic [9:0]  cellCtl;
  logic        endSmall, doneBig;

  always #5 clk = ~clk;

  neuro_seq #(.NEURONS(NEUR), .BW(BW)) dut_i (
    .clk(clk), .rstN(rstN), .waitReq(waitReq), .debugMode(debugMode),
    .ramAddr(ramAddr), .ramRd(ramRd), .ramWr(ramWr), .ramRdData(ramRdData),
    .ramWrData(ramWrData), .neuronSel(neuronSel), .accHigh(accHigh),
    .actData(actData), .cellCtl(cellCtl), .endSmall(endSmall), .doneBig(doneBig)
  );

  // RAM and neuron stubs
  logic [7:0] mem [0:2047];
  logic [7:0] accStub [0:7];
  logic [7:0] stubAct [0:7];

  always @(posedge clk) if (ramRd) ramRdData <= mem[ramAddr];
  assign accHigh = accStub[neuronSel];
  always @(posedge clk) if (cellCtl[0]) stubAct[neuronSel] <= actData;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor
  int rdAddr [0:63];
  int rdCyc  [0:63];
  int wrAddr [0:63];
  int wrData [0:63];
  int wrCyc  [0:63];
  int ccCnt  [0:9];
  int nRd, nWr, esCnt, esCyc, doneCnt, doneCyc, actCnt;

  always @(negedge clk) begin
    if (rstN) begin
      if (ramRd && nRd < 64) begin
        rdAddr[nRd] = int'(ramAddr); rdCyc[nRd] = cyc; nRd++;
      end
      if (ramWr && nWr < 64) begin
        wrAddr[nWr] = int'(ramAddr); wrData[nWr] = int'(ramWrData);
        wrCyc[nWr] = cyc; nWr++;
      end
      for (int b = 0; b < 10; b++) if (cellCtl[b]) ccCnt[b]++;
      if (endSmall) begin esCnt++; esCyc = cyc; end
      if (doneBig) begin doneCnt++; doneCyc = cyc; end
      if (ramRd || ramWr || (cellCtl != '0)) actCnt++;
    end
  end

  task automatic clearMon();
    nRd = 0; nWr = 0; esCnt = 0; esCyc = 0; doneCnt = 0; doneCyc = 0; actCnt = 0;
    for (int b = 0; b < 10; b++) ccCnt[b] = 0;
  endtask

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int expLook(input logic [7:0] dir, input int n);
    return dir[n] ? (32'h700 + n) : (n * 256 + int'(accStub[n]));
  endfunction

  bit prevDbg = 0;

  task automatic runBig(input bit dbg, input logic [7:0] dirByte,
                        input int pStart, input int pLen, input bit midHold);
    int  relCyc, k, snap, lat;
    bit  held;
    for (int a = 0; a < 2048; a++) mem[a] = 8'($urandom);
    mem[11'h7FF] = dirByte;
    for (int n = 0; n < 8; n++) accStub[n] = 8'($urandom);
    debugMode = dbg;
    // R2: still held at the stopping point
    clearMon();
    repeat (3) @(negedge clk);
    #1;
    chk(actCnt == 0, "R2 hold while waitReq high", actCnt, 0);
    lat = prevDbg ? 2 : 1;
    @(negedge clk); #1;
    clearMon();
    relCyc = cyc;
    waitReq = 1'b0;
    k = 0; held = 0;
    forever begin
      @(negedge clk); #1;
      k++;
      if (pLen > 0 && k == pStart) waitReq = 1'b1;
      if (pLen > 0 && k == pStart + pLen) waitReq = 1'b0;
      if (!dbg && doneCnt > 0) begin waitReq = 1'b1; break; end
      if (dbg && midHold && !held && nWr == NEUR) begin
        waitReq = 1'b1;
        snap = actCnt;
        repeat (20) @(negedge clk);
        #1;
        chk(actCnt == snap, "R11 no activity while paused", actCnt, snap);
        chk(nWr == NEUR, "R11 write count while paused", nWr, NEUR);
        waitReq = 1'b0;
        held = 1;
      end
      if (dbg && nWr == NEUR * BW) begin waitReq = 1'b1; break; end
      if (k > 5000) begin
        chk(0, "R9 round never finished", k, 0);
        waitReq = 1'b1;
        break;
      end
    end
    repeat (4) @(negedge clk);
    #1;
    // Burst checks
    chk(nRd == 7, "R3 read count", nRd, 7);
    chk(rdAddr[0] == 32'h7FF, "R2 first read is source byte", rdAddr[0], 32'h7FF);
    chk(rdCyc[0] == relCyc + lat, "R2 release latency", rdCyc[0] - relCyc, lat);
    for (int i = 0; i < NEUR; i++) begin
      int n, ea;
      n = NEUR - 1 - i;
      ea = expLook(dirByte, n);
      chk(rdAddr[i+1] == ea, "R4 lookup address", rdAddr[i+1], ea);
      chk(rdCyc[i+1] == rdCyc[0] + 2 + 2*i, "R3 read spacing",
          rdCyc[i+1] - rdCyc[0], 2 + 2*i);
      chk(stubAct[n] == mem[ea], "R5 loaded activation", int'(stubAct[n]), int'(mem[ea]));
    end
    // Strobe counts
    chk(ccCnt[0] == NEUR, "R5 load strobes", ccCnt[0], NEUR);
    chk(ccCnt[1] == 1 && ccCnt[2] == 8, "R6 clear/preload", ccCnt[1]*100 + ccCnt[2], 108);
    chk(ccCnt[3] == 2*BW, "R6 token strobes", ccCnt[3], 2*BW);
    for (int b = 4; b < 8; b++)
      chk(ccCnt[b] == 8*BW, "R6 shift/multiply strobes", ccCnt[b], 8*BW);
    chk(ccCnt[8] == BW, "R6 carry strobes", ccCnt[8], BW);
    chk(esCnt == 1, "R7 endSmall once per pass", esCnt, 1);
    if (!dbg) begin
      chk(nWr == NEUR, "R8 write count", nWr, NEUR);
      chk(ccCnt[9] == NEUR, "R8 read-acc strobes", ccCnt[9], NEUR);
      chk(wrCyc[0] == esCyc + 1, "R7 endSmall before writes", wrCyc[0] - esCyc, 1);
      for (int i = 0; i < NEUR; i++) begin
        chk(wrAddr[i] == 32'h708 + NEUR - 1 - i, "R8 output slot", wrAddr[i],
            32'h708 + NEUR - 1 - i);
        chk(wrData[i] == int'(accStub[NEUR-1-i]), "R8 output data", wrData[i],
            int'(accStub[NEUR-1-i]));
      end
      chk(doneCnt == 1, "R9 done count", doneCnt, 1);
      chk(doneCyc == wrCyc[NEUR-1] + 1, "R9 done after last write",
          doneCyc - wrCyc[NEUR-1], 1);
      chk(doneCyc - rdCyc[0] == 29 + 36*BW, "R9 R12 round length",
          doneCyc - rdCyc[0], 29 + 36*BW);
    end else begin
      chk(nWr == NEUR*BW, "R10 debug write count", nWr, NEUR*BW);
      for (int j = 0; j < NEUR*BW; j++) begin
        int n;
        n = NEUR - 1 - (j % NEUR);
        chk(wrAddr[j] == 32'h708 + n, "R10 debug output slot", wrAddr[j], 32'h708 + n);
        chk(wrData[j] == int'(accStub[n]), "R10 debug output data", wrData[j],
            int'(accStub[n]));
      end
      chk(doneCnt == 0, "R10 no done in debug", doneCnt, 0);
    end
    prevDbg = dbg;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) begin accStub[n] = 8'h00; stubAct[n] = 8'h00; end
    rstN = 1'b0; waitReq = 1'b1; debugMode = 1'b0;
    clearMon();
    repeat (3) @(negedge clk);
    chk(!ramRd && !ramWr && cellCtl == '0 && !endSmall && !doneBig,
        "R1 outputs in reset", int'(cellCtl), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(actCnt == 0 && !endSmall && !doneBig, "R1 quiet after reset", actCnt, 0);

    runBig(0, 8'h00, 0, 0, 0);                       // all table lookups
    runBig(0, 8'h3F, 0, 0, 0);                       // all host inputs
    runBig(0, 8'hC0, 0, 0, 0);                       // R4: bits 6,7 ignored
    for (int r = 0; r < 3; r++) runBig(0, 8'($urandom), 0, 0, 0);
    runBig(0, 8'($urandom), 40, 30, 0);              // R12: pulse mid-levels
    runBig(0, 8'($urandom), 3, 6, 0);                // R12: pulse during burst
    runBig(1, 8'($urandom), 0, 0, 1);                // R11: pause between levels
    runBig(1, 8'($urandom), 0, 0, 0);
    runBig(0, 8'($urandom), 0, 0, 0);                // back to normal after debug

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule